// File: doc/BRIEF.md
# Directed-Rounding Mantissa Rounder

This block is the rounding stage of a floating-point result path. The caller delivers a mantissa that has already been aligned so that its two least significant bits are the guard bit (upper) and the round bit (lower). A separate sticky bit summarises everything shifted out below them. The block also takes the sign of the result and a two-bit rounding mode. It drops the guard and round bits and adds one at the new least significant bit when the mode and sign call for rounding up. It reports whether the result was inexact and whether it was rounded up. A carry-out shows that the mantissa overflowed to the next power of two; the block passes that value through unchanged, and the caller corrects the exponent.

A second path serves the caller once it has found that the exponent overflowed. From the mode and the sign, it decides whether the result becomes infinity, which raises the overflow flag, or the largest finite magnitude. All outputs are registered once, so results appear one clock after the inputs are sampled.

Top module: `rnd_stage`

## Requirements
- R1: Outputs are registered. Values on the inputs at one rising clock edge determine the outputs after that edge. When no increment occurs, {carry_o, mant_o} equals the input mantissa shifted right by two, with carry_o = 0.
- R2: When guard (mant_i[1]), round (mant_i[0]) and sticky_i are all 0, no increment occurs and inexact_o, frac_inexact_o and rounded_up_o are all 0.
- R3: When any of guard, round or sticky_i is 1, inexact_o and frac_inexact_o are both 1.
- R4: In mode 2'b00 (nearest), the result rounds up only when guard is 1 and at least one of these is 1: round, sticky_i, or mant_i[2] (the shifted LSB). A tie therefore rounds to even.
- R5: In mode 2'b01 (toward zero), the result never rounds up.
- R6: In mode 2'b10 (toward plus infinity), the result rounds up on any inexact input only when sign_i = 0. In mode 2'b11 (toward minus infinity), it rounds up on any inexact input only when sign_i = 1.
- R7: On an increment, rounded_up_o is 1 and {carry_o, mant_o} equals the shifted mantissa plus one, with the carry propagated through every bit.
- R8: When a mantissa of all ones is incremented, the result is mant_o = 0 and carry_o = 1; the block does not renormalise it.
- R9: With ovf_i = 1, ovf_to_inf_o is 1 in these cases: always in nearest, never toward zero, toward plus infinity when sign_i = 0, and toward minus infinity when sign_i = 1. Otherwise ovf_to_max_o is 1. With ovf_i = 0, both are 0. The two are never 1 together.
- R10: While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mant_i | input | MANT_W+2 | Aligned mantissa; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of all bits below round |
| sign_i | input | 1 | Result sign, 1 = negative |
| mode_i | input | 2 | 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| ovf_i | input | 1 | Caller reports exponent overflow |
| mant_o | output | MANT_W | Rounded mantissa |
| carry_o | output | 1 | Rounded mantissa reached the next power of two |
| inexact_o | output | 1 | Result not exact |
| frac_inexact_o | output | 1 | Fraction inexact |
| rounded_up_o | output | 1 | Fraction was incremented |
| ovf_to_inf_o | output | 1 | Overflow goes to infinity; this is also the overflow flag |
| ovf_to_max_o | output | 1 | Overflow goes to the largest finite magnitude |

## Verification
A wrong round-up decision shows at the ports in the same cycle. The mantissa comes out off by one at the LSB, and rounded_up_o disagrees with the mode and sign that were sampled one clock earlier. A broken carry chain shows only on long runs of ones, so the all-ones and half-ones patterns check the high carry bits. Swapping the two directed modes, or treating a sign as inverted, changes both the increment decision and the choice between infinity and the largest finite value on the next cycle.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_PINF = 2'b10,
    RM_NINF = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic      guard_i,
  input  logic      rbit_i,
  input  logic      sticky_i,
  input  logic      lsb_i,
  input  logic      sign_i,
  input  rnd_mode_e mode_i,
  output logic      inexact_o,
  output logic      up_o
);
  logic lost;
  assign lost = guard_i | rbit_i | sticky_i;
  assign inexact_o = lost;

  always_comb begin
    up_o = 1'b0;
    if (lost) begin
      unique case (mode_i)
        RM_NEAR: up_o = guard_i & (rbit_i | sticky_i | lsb_i);
        RM_ZERO: up_o = 1'b0;
        RM_PINF: up_o = ~sign_i;
        RM_NINF: up_o = sign_i;
        default: up_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int W = 24
) (
  input  logic [W-1:0] a_i,
  input  logic         inc_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = inc_i;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ c[i];
    assign c[i+1]   = a_i[i] & c[i];
  end
  assign cout_o = c[W];
endmodule

// File: rtl/rnd_ovf.sv
module rnd_ovf
  import rnd_pkg::*;
(
  input  logic      ovf_i,
  input  logic      sign_i,
  input  rnd_mode_e mode_i,
  output logic      to_inf_o,
  output logic      to_max_o
);
  logic pick_inf;
  always_comb begin
    unique case (mode_i)
      RM_NEAR: pick_inf = 1'b1;
      RM_ZERO: pick_inf = 1'b0;
      RM_PINF: pick_inf = ~sign_i;
      RM_NINF: pick_inf = sign_i;
      default: pick_inf = 1'b1;
    endcase
  end
  assign to_inf_o = ovf_i & pick_inf;
  assign to_max_o = ovf_i & ~pick_inf;
endmodule

// File: rtl/rnd_stage.sv
module rnd_stage
  import rnd_pkg::*;
#(
  parameter int MANT_W = 24,
  localparam int IN_W = MANT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IN_W-1:0]   mant_i,
  input  logic              sticky_i,
  input  logic              sign_i,
  input  logic [1:0]        mode_i,
  input  logic              ovf_i,
  output logic [MANT_W-1:0] mant_o,
  output logic              carry_o,
  output logic              inexact_o,
  output logic              frac_inexact_o,
  output logic              rounded_up_o,
  output logic              ovf_to_inf_o,
  output logic              ovf_to_max_o
);
  rnd_mode_e           mode;
  logic [MANT_W-1:0]   base, sum;
  logic                cout, inx, up, to_inf, to_max;

  assign mode = rnd_mode_e'(mode_i);
  assign base = mant_i[IN_W-1:2];

  rnd_decide u_decide (
    .guard_i  (mant_i[1]),
    .rbit_i   (mant_i[0]),
    .sticky_i (sticky_i),
    .lsb_i    (mant_i[2]),
    .sign_i   (sign_i),
    .mode_i   (mode),
    .inexact_o(inx),
    .up_o     (up)
  );

  rnd_incr #(.W(MANT_W)) u_incr (
    .a_i   (base),
    .inc_i (up),
    .sum_o (sum),
    .cout_o(cout)
  );

  rnd_ovf u_ovf (
    .ovf_i   (ovf_i),
    .sign_i  (sign_i),
    .mode_i  (mode),
    .to_inf_o(to_inf),
    .to_max_o(to_max)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mant_o         <= '0;
      carry_o        <= 1'b0;
      inexact_o      <= 1'b0;
      frac_inexact_o <= 1'b0;
      rounded_up_o   <= 1'b0;
      ovf_to_inf_o   <= 1'b0;
      ovf_to_max_o   <= 1'b0;
    end else begin
      mant_o         <= sum;
      carry_o        <= cout;
      inexact_o      <= inx;
      frac_inexact_o <= inx;
      rounded_up_o   <= up;
      ovf_to_inf_o   <= to_inf;
      ovf_to_max_o   <= to_max;
    end
  end
endmodule

// File: rtl/rnd_stage_chk.sv
module rnd_stage_chk #(
  parameter int MANT_W = 24,
  localparam int IN_W = MANT_W + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IN_W-1:0]   mant_i,
  input logic              sticky_i,
  input logic              sign_i,
  input logic [1:0]        mode_i,
  input logic              ovf_i,
  input logic [MANT_W-1:0] mant_o,
  input logic              carry_o,
  input logic              inexact_o,
  input logic              frac_inexact_o,
  input logic              rounded_up_o,
  input logic              ovf_to_inf_o,
  input logic              ovf_to_max_o
);
  logic primed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  // R1
  pass_thru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    !rounded_up_o |-> ({carry_o, mant_o} == {1'b0, $past(mant_i[IN_W-1:2])}));
  // R2
  exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    ($past(mant_i[1:0]) == 2'b00 && !$past(sticky_i)) |-> (!inexact_o && !rounded_up_o));
  // R3
  inexact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    ($past(mant_i[1:0]) != 2'b00 || $past(sticky_i)) |-> (inexact_o && frac_inexact_o));
  // R5
  no_up_rz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    ($past(mode_i) == 2'b01) |-> !rounded_up_o);
  // R7
  incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    rounded_up_o |-> ({carry_o, mant_o} == {1'b0, $past(mant_i[IN_W-1:2])} + 1'b1));
  // R9
  ovf_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ovf_to_inf_o, ovf_to_max_o}) <= 1);
  // R9
  ovf_rz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    ($past(ovf_i) && $past(mode_i) == 2'b01) |-> (ovf_to_max_o && !ovf_to_inf_o));
endmodule

bind rnd_stage rnd_stage_chk #(.MANT_W(MANT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mant_i        (mant_i),
  .sticky_i      (sticky_i),
  .sign_i        (sign_i),
  .mode_i        (mode_i),
  .ovf_i         (ovf_i),
  .mant_o        (mant_o),
  .carry_o       (carry_o),
  .inexact_o     (inexact_o),
  .frac_inexact_o(frac_inexact_o),
  .rounded_up_o  (rounded_up_o),
  .ovf_to_inf_o  (ovf_to_inf_o),
  .ovf_to_max_o  (ovf_to_max_o)
);

// File: tb/rnd_stage_tb.sv
module rnd_stage_tb;
  localparam int MW = 24;
  localparam int IW = MW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0] mant = '0;
  logic sticky = 1'b0, sign = 1'b0, ovf = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [MW-1:0] mant_q;
  logic carry_q, inx_q, finx_q, up_q, inf_q, max_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rnd_stage #(.MANT_W(MW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mant_i(mant), .sticky_i(sticky),
    .sign_i(sign), .mode_i(mode), .ovf_i(ovf), .mant_o(mant_q),
    .carry_o(carry_q), .inexact_o(inx_q), .frac_inexact_o(finx_q),
    .rounded_up_o(up_q), .ovf_to_inf_o(inf_q), .ovf_to_max_o(max_q)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at negedge, sample one rising edge later.
  task automatic apply(logic [IW-1:0] m, logic s, logic sg, logic [1:0] md, logic ov);
    @(negedge clk);
    mant = m; sticky = s; sign = sg; mode = md; ovf = ov;
    @(posedge clk);
    #1;
  endtask

  task automatic round_case(string req, logic [IW-1:0] m, logic s, logic sg, logic [1:0] md);
    logic g, r, lost, up;
    logic [MW:0] res;
    g = m[1]; r = m[0];
    lost = g | r | s;
    case (md)
      2'b00: up = g & (r | s | m[2]);
      2'b01: up = 1'b0;
      2'b10: up = lost & ~sg;
      default: up = lost & sg;
    endcase
    res = {1'b0, m[IW-1:2]} + {{MW{1'b0}}, up};
    apply(m, s, sg, md, 1'b0);
    check(req, {carry_q, mant_q}, res);
    check(req, up_q, up);
    check(req, {inx_q, finx_q}, {lost, lost});
  endtask

  task automatic ovf_case(string req, logic sg, logic [1:0] md, logic ov);
    logic inf;
    inf = (md == 2'b00) | (md == 2'b10 && !sg) | (md == 2'b11 && sg);
    apply({IW{1'b0}}, 1'b0, sg, md, ov);
    check(req, {inf_q, max_q}, {ov & inf, ov & ~inf});
  endtask

  task automatic t_reset();
    check("R10", {mant_q, carry_q, inx_q, finx_q, up_q, inf_q, max_q}, '0);
  endtask

  task automatic t_exact();
    round_case("R2", {24'h123456, 2'b00}, 1'b0, 1'b0, 2'b00);
    round_case("R2", {24'hFFFFFF, 2'b00}, 1'b0, 1'b1, 2'b11);
    round_case("R1", {24'hABCDEF, 2'b00}, 1'b0, 1'b0, 2'b10);
  endtask

  task automatic t_nearest();
    round_case("R4", {24'h000010, 2'b10}, 1'b0, 1'b0, 2'b00); // tie, even: stay
    round_case("R4", {24'h000011, 2'b10}, 1'b0, 1'b0, 2'b00); // tie, odd: up
    round_case("R4", {24'h000010, 2'b10}, 1'b1, 1'b0, 2'b00); // above half via sticky
    round_case("R4", {24'h000010, 2'b11}, 1'b0, 1'b1, 2'b00); // above half via round
    round_case("R3", {24'h000011, 2'b01}, 1'b1, 1'b0, 2'b00); // below half
  endtask

  task automatic t_directed();
    round_case("R5", {24'h7FFFFF, 2'b11}, 1'b1, 1'b0, 2'b01);
    round_case("R5", {24'h7FFFFF, 2'b11}, 1'b1, 1'b1, 2'b01);
    round_case("R6", {24'h000100, 2'b00}, 1'b1, 1'b0, 2'b10);
    round_case("R6", {24'h000100, 2'b01}, 1'b0, 1'b1, 2'b10);
    round_case("R6", {24'h000100, 2'b01}, 1'b0, 1'b1, 2'b11);
    round_case("R6", {24'h000100, 2'b00}, 1'b1, 1'b0, 2'b11);
  endtask

  task automatic t_carry();
    round_case("R7", {24'h00FFFF, 2'b11}, 1'b0, 1'b0, 2'b00);
    round_case("R7", {24'h7FFFFF, 2'b10}, 1'b1, 1'b0, 2'b00);
    round_case("R8", {24'hFFFFFF, 2'b10}, 1'b1, 1'b0, 2'b00);
    round_case("R8", {24'hFFFFFF, 2'b01}, 1'b0, 1'b1, 2'b11);
  endtask

  task automatic t_overflow();
    for (int md = 0; md < 4; md++) begin
      for (int sg = 0; sg < 2; sg++) begin
        ovf_case("R9", sg[0], md[1:0], 1'b1);
      end
    end
    ovf_case("R9", 1'b0, 2'b00, 1'b0);
    ovf_case("R9", 1'b1, 2'b01, 1'b0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_exact();
    t_nearest();
    t_directed();
    t_carry();
    t_overflow();
    // R10: async reset clears a live result
    apply({24'hFFFFFF, 2'b11}, 1'b1, 1'b0, 2'b00, 1'b1);
    rst_n = 1'b0;
    #1;
    t_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule